// File: doc/BRIEF.md
# Modem Handshake Line Manager

This block drives the modem-side control outputs of a serial modem: clear-to-send, data-set-ready and carrier-detect, all active-low, plus an active-high lock indicator. It works from the terminal-side request-to-send and terminal-ready inputs, the link lock status and the loopback state of the modem. A select input picks one of two personalities. In channel mode the two terminal-side lines are carried as slow data channels. They are sampled once per sample period and handed out as local channel bits for transport. The channel bits received from the far end are shown on clear-to-send and data-set-ready. In handshake mode the lines behave as classic modem handshake signals that depend on lock and on the loopback state.

The terminal-side inputs and the select input cross into the clock domain through multi-flop synchronisers. The sample period, in clock cycles, is a parameter, with a default of 1536. All outputs are registered. A synchronous active-high reset puts every handshake output in its inactive (high) level.

Top module: `modem_ctl_mgr`

## Requirements
- R1: While reset is held, cts_n_o, dsr_n_o and dcd_n_o are 1, lock_ind_o is 0 and loc_ch_o is 2'b11.
- R2: In channel mode (hs_sel_i = 0), loc_ch_o[0] carries the request line and loc_ch_o[1] carries the ready line. Both are sampled once every SAMPLE_DIV cycles. An input change made just after a sample is not visible on loc_ch_o until the next sample.
- R3: In channel mode with no loopback, cts_n_o shows far_ch_i[0] and dsr_n_o shows far_ch_i[1], captured at the same sample instant. Between samples they hold their value.
- R4: In handshake mode (hs_sel_i = 1), dsr_n_o is driven low to signal that the modem is alive.
- R5: In handshake mode, cts_n_o is low exactly when lock_i is 1 and rts_n_i is low. A change of rts_n_i reaches cts_n_o on the third rising edge after it, and not earlier.
- R6: In handshake mode, dcd_n_o is low only when lock_i is 1, dtr_n_i is low and the loopback state allows carrier. Raising dtr_n_i drives dcd_n_o high.
- R7: When lock_i falls in handshake mode, cts_n_o and dcd_n_o are both forced high on the next rising edge.
- R8: The loopback state resolves with this priority: local over remote-initiator over remote-far-end. Local and remote-far-end force dcd_n_o high. Remote-initiator allows dcd_n_o low while locked. This holds in both modes; in channel mode carrier depends only on lock and loopback.
- R9: In channel mode with any loopback active, cts_n_o and dsr_n_o show the locally sampled request and ready lines instead of the far-end bits.
- R10: lock_ind_o equals lock_i delayed by one cycle, regardless of rts_n_i, dtr_n_i, the mode and the loopback flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rts_n_i | input | 1 | Terminal request-to-send, active low, asynchronous |
| dtr_n_i | input | 1 | Terminal ready, active low, asynchronous |
| hs_sel_i | input | 1 | Personality select: 0 channel mode, 1 handshake mode |
| lock_i | input | 1 | Link synchronisation achieved |
| loc_loop_i | input | 1 | Local loopback requested |
| rem_near_i | input | 1 | Remote loopback, this end initiated it |
| rem_far_i | input | 1 | Remote loopback, this end loops the far end's data |
| far_ch_i | input | 2 | Channel bits received from the far end: [0] request, [1] ready |
| cts_n_o | output | 1 | Clear-to-send, active low |
| dsr_n_o | output | 1 | Data-set-ready, active low |
| dcd_n_o | output | 1 | Carrier detect, active low |
| lock_ind_o | output | 1 | Raw lock indicator, active high |
| loc_ch_o | output | 2 | Local channel bits to transmit: [0] request, [1] ready |

## Verification
The bench builds the block with SAMPLE_DIV = 16 and two synchroniser stages. The short period puts many sample instants within a few hundred cycles. The bench finds a sample instant by watching loc_ch_o. It then changes inputs right after that instant and shows that the outputs hold for a whole period before they move. The two-stage synchroniser gives a fixed three-edge latency in handshake mode. The bench checks this on both sides of the edge where the output changes.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

  typedef enum logic [1:0] {
    LP_NONE     = 2'd0,
    LP_LOCAL    = 2'd1,
    LP_REM_NEAR = 2'd2,
    LP_REM_FAR  = 2'd3
  } loop_e;

  // Local loopback wins over remote; the initiating side wins over the far side.
  function automatic loop_e resolve_loop(input logic loc, input logic near, input logic far);
    if (loc)       return LP_LOCAL;
    else if (near) return LP_REM_NEAR;
    else if (far)  return LP_REM_FAR;
    else           return LP_NONE;
  endfunction

  // Carrier is withheld in local loopback and on the looping far end.
  function automatic logic carrier_allowed(input loop_e lp);
    return (lp == LP_NONE) || (lp == LP_REM_NEAR);
  endfunction

endpackage

// File: rtl/mcm_sync.sv
module mcm_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= RST_VAL;
    else     chain_q[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= RST_VAL;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mcm_tick.sv
module mcm_tick #(
  parameter int DIV = 1536,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (cnt_q == CW'(DIV - 1));
      if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DIV - 1));

  generate
    if (DIV > 1) begin : g_gap
      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);
    end
  endgenerate

endmodule

// File: rtl/mcm_chan.sv
module mcm_chan
  import mcm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       rts_s_i,
  input  logic       dtr_s_i,
  input  loop_e      loop_i,
  input  logic [1:0] far_ch_i,
  output logic [1:0] loc_ch_o,
  output logic       cts_n_o,
  output logic       dsr_n_o
);

  logic [1:0] loc_q;
  logic       cts_q;
  logic       dsr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_q <= 2'b11;
      cts_q <= 1'b1;
      dsr_q <= 1'b1;
    end else if (tick_i) begin
      loc_q <= {dtr_s_i, rts_s_i};
      if (loop_i != LP_NONE) begin
        cts_q <= rts_s_i;
        dsr_q <= dtr_s_i;
      end else begin
        cts_q <= far_ch_i[0];
        dsr_q <= far_ch_i[1];
      end
    end
  end

  assign loc_ch_o = loc_q;
  assign cts_n_o  = cts_q;
  assign dsr_n_o  = dsr_q;

  // R2
  loc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(loc_q));

  // R3
  far_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> ($stable(cts_q) && $stable(dsr_q)));

endmodule

// File: rtl/mcm_hshk.sv
module mcm_hshk
  import mcm_pkg::*;
(
  input  logic  rts_s_i,
  input  logic  dtr_s_i,
  input  logic  lock_i,
  input  loop_e loop_i,
  output logic  cts_n_o,
  output logic  dsr_n_o,
  output logic  dcd_n_o
);

  always_comb begin
    cts_n_o = !(lock_i && !rts_s_i);
    dsr_n_o = 1'b0;
    dcd_n_o = !(lock_i && !dtr_s_i && carrier_allowed(loop_i));
  end

endmodule

// File: rtl/modem_ctl_mgr.sv
module modem_ctl_mgr
  import mcm_pkg::*;
#(
  parameter int SAMPLE_DIV  = 1536,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rts_n_i,
  input  logic       dtr_n_i,
  input  logic       hs_sel_i,
  input  logic       lock_i,
  input  logic       loc_loop_i,
  input  logic       rem_near_i,
  input  logic       rem_far_i,
  input  logic [1:0] far_ch_i,
  output logic       cts_n_o,
  output logic       dsr_n_o,
  output logic       dcd_n_o,
  output logic       lock_ind_o,
  output logic [1:0] loc_ch_o
);

  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] sync_s;
  logic rts_s, dtr_s, sel_s;
  logic tick;
  loop_e loop;
  logic ch_cts, ch_dsr;
  logic hs_cts, hs_dsr, hs_dcd;
  logic cts_q, dsr_q, dcd_q, lock_q;

  mcm_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b011)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i({hs_sel_i, dtr_n_i, rts_n_i}),
    .q_o(sync_s)
  );

  assign rts_s = sync_s[0];
  assign dtr_s = sync_s[1];
  assign sel_s = sync_s[2];
  assign loop  = resolve_loop(loc_loop_i, rem_near_i, rem_far_i);

  mcm_tick #(.DIV(SAMPLE_DIV)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .tick_o(tick)
  );

  mcm_chan u_chan (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .rts_s_i (rts_s),
    .dtr_s_i (dtr_s),
    .loop_i  (loop),
    .far_ch_i(far_ch_i),
    .loc_ch_o(loc_ch_o),
    .cts_n_o (ch_cts),
    .dsr_n_o (ch_dsr)
  );

  mcm_hshk u_hshk (
    .rts_s_i(rts_s),
    .dtr_s_i(dtr_s),
    .lock_i (lock_i),
    .loop_i (loop),
    .cts_n_o(hs_cts),
    .dsr_n_o(hs_dsr),
    .dcd_n_o(hs_dcd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_q  <= 1'b1;
      dsr_q  <= 1'b1;
      dcd_q  <= 1'b1;
      lock_q <= 1'b0;
    end else begin
      lock_q <= lock_i;
      if (sel_s) begin
        cts_q <= hs_cts;
        dsr_q <= hs_dsr;
        dcd_q <= hs_dcd;
      end else begin
        cts_q <= ch_cts;
        dsr_q <= ch_dsr;
        dcd_q <= !(lock_i && carrier_allowed(loop));
      end
    end
  end

  assign cts_n_o    = cts_q;
  assign dsr_n_o    = dsr_q;
  assign dcd_n_o    = dcd_q;
  assign lock_ind_o = lock_q;

  // R4
  alive_dsr_chk: assert property (@(posedge clk) disable iff (rst)
    sel_s |=> !dsr_n_o);

  // R7
  lock_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_s && !lock_i) |=> (cts_n_o && dcd_n_o));

  // R8
  local_loop_dcd_chk: assert property (@(posedge clk) disable iff (rst)
    loc_loop_i |=> dcd_n_o);

  // R10
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> lock_ind_o);

  // R10
  lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_i |=> !lock_ind_o);

endmodule

// File: tb/modem_ctl_mgr_bench.sv
module modem_ctl_mgr_bench;

  localparam int DIV = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rts_n = 1'b1, dtr_n = 1'b1, sel = 1'b0, lock = 1'b0;
  logic loc_loop = 1'b0, rem_near = 1'b0, rem_far = 1'b0;
  logic [1:0] far_ch = 2'b11;
  logic cts_n, dsr_n, dcd_n, lock_ind;
  logic [1:0] loc_ch;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  modem_ctl_mgr #(.SAMPLE_DIV(DIV), .SYNC_STAGES(2)) u_modem_ctl_mgr (
    .clk(clk), .rst(rst), .rts_n_i(rts_n), .dtr_n_i(dtr_n), .hs_sel_i(sel),
    .lock_i(lock), .loc_loop_i(loc_loop), .rem_near_i(rem_near), .rem_far_i(rem_far),
    .far_ch_i(far_ch), .cts_n_o(cts_n), .dsr_n_o(dsr_n), .dcd_n_o(dcd_n),
    .lock_ind_o(lock_ind), .loc_ch_o(loc_ch)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1 cts", cts_n, 1); chk("R1 dsr", dsr_n, 1); chk("R1 dcd", dcd_n, 1);
    chk("R1 lock_ind", lock_ind, 0); chk("R1 loc_ch", loc_ch, 3);
    rst = 1'b0;
  endtask

  task automatic t_chan_sample();
    sel = 0; lock = 1; far_ch = 2'b10; rts_n = 0; dtr_n = 1;
    cyc(DIV + 6);
    chk("R2 loc_ch", loc_ch, 2);
    chk("R3 cts far", cts_n, 0); chk("R3 dsr far", dsr_n, 1);
    // locate a sample instant
    rts_n = 1;
    for (int i = 0; i < DIV + 6; i++) begin
      @(negedge clk);
      if (loc_ch[0] == 1'b1) break;
    end
    chk("R2 sample seen", loc_ch, 3);
    rts_n = 0; dtr_n = 0; far_ch = 2'b01;
    cyc(DIV - 2);
    chk("R2 hold loc_ch", loc_ch, 3);
    chk("R3 hold cts", cts_n, 0); chk("R3 hold dsr", dsr_n, 1);
    cyc(4);
    chk("R2 next sample", loc_ch, 0);
    chk("R3 new cts", cts_n, 1); chk("R3 new dsr", dsr_n, 0);
    chk("R8 chan dcd locked", dcd_n, 0);
  endtask

  task automatic t_chan_loop();
    far_ch = 2'b11; rts_n = 0; dtr_n = 1; loc_loop = 1;
    cyc(DIV + 6);
    chk("R9 local cts", cts_n, 0); chk("R9 local dsr", dsr_n, 1);
    chk("R8 chan local dcd", dcd_n, 1);
    loc_loop = 0; rem_near = 1; dtr_n = 0;
    cyc(DIV + 6);
    chk("R9 remote cts", cts_n, 0); chk("R9 remote dsr", dsr_n, 0);
    chk("R8 chan near dcd", dcd_n, 0);
    rem_near = 0;
  endtask

  task automatic t_hs_basic();
    sel = 1; lock = 1; rts_n = 1; dtr_n = 0;
    cyc(5);
    chk("R4 dsr alive", dsr_n, 0);
    chk("R6 dcd locked", dcd_n, 0);
    chk("R5 cts idle", cts_n, 1);
    rts_n = 0;
    cyc(2);
    chk("R5 cts not yet", cts_n, 1);
    cyc(1);
    chk("R5 cts on 3rd edge", cts_n, 0);
    rts_n = 1;
    cyc(3);
    chk("R5 cts released", cts_n, 1);
    rts_n = 0; dtr_n = 1;
    cyc(3);
    chk("R6 dtr high dcd", dcd_n, 1);
    chk("R5 cts active", cts_n, 0);
    dtr_n = 0;
    cyc(3);
  endtask

  task automatic t_lock_loss();
    lock = 0;
    cyc(1);
    chk("R7 cts forced", cts_n, 1); chk("R7 dcd forced", dcd_n, 1);
    chk("R4 dsr stays", dsr_n, 0);
    lock = 1;
    cyc(1);
    chk("R7 cts back", cts_n, 0); chk("R7 dcd back", dcd_n, 0);
  endtask

  task automatic t_hs_loops();
    loc_loop = 1; cyc(1);
    chk("R8 local dcd", dcd_n, 1);
    rem_near = 1; cyc(1);
    chk("R8 local wins", dcd_n, 1);
    loc_loop = 0; cyc(1);
    chk("R8 near dcd", dcd_n, 0);
    rem_far = 1; cyc(1);
    chk("R8 near over far", dcd_n, 0);
    rem_near = 0; cyc(1);
    chk("R8 far dcd", dcd_n, 1);
    rem_far = 0; cyc(1);
    chk("R8 no loop dcd", dcd_n, 0);
  endtask

  task automatic t_lock_ind();
    for (int i = 0; i < 8; i++) begin
      lock = i[0] ^ i[2]; rts_n = i[1]; dtr_n = i[0]; sel = i[2]; loc_loop = i[1] & i[0];
      cyc(1);
      chk("R10 lock_ind", lock_ind, int'(i[0] ^ i[2]));
    end
    loc_loop = 0;
  endtask

  initial begin
    t_reset();
    t_chan_sample();
    t_chan_loop();
    t_hs_basic();
    t_lock_loss();
    t_hs_loops();
    t_lock_ind();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule